// File: doc/BRIEF.md
# Quad SPI Command Snoop Sequencer

This block sits beside the byte path that feeds a serial flash and follows each transaction as it goes out. The first byte after chip select goes active is taken as the opcode. The block decodes it to find three things: how many address bytes follow, how many dummy bytes follow, and whether the link widens from one line to two or four lines. A widening can take effect at once, or only after the address and dummy bytes have gone out. The block then steps through the address, dummy and data phases one accepted byte at a time. For every byte it tells the shifter how many lines to use. For each dummy byte it also gives the number of clock cycles that byte takes. A data-phase flag tells the shifter to spread bytes across the lines.

The byte input is a valid/ready stream. The block never applies back-pressure, so `in_ready` is always high, and a byte is accepted on any rising edge where `in_valid` and `cs_active` are both high. The opcode table and the extended-address bit decide the sequence. Dropping chip select ends the transaction at the next edge. All outputs come from registers and change only on the edge that accepts a byte or sees chip select low.

Top module: `qspi_cmd_snoop`

## Requirements
- R1: After reset, and on the edge after any cycle with `cs_active` low, `phase` is 0 (opcode), `link_width` is 1, `dummy_clks` is 0, `stripe_mode` is 0, and any pending width change is dropped.
- R2: An opcode byte not listed in R3 or R4 moves `phase` to 4 (pass-through). `phase` then stays 4 and `link_width` stays 1 until chip select drops.
- R3: A listed opcode moves `phase` to 1 (address). The address phase lasts 4 accepted bytes for 0x13, 0x12, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC and 0x34. For every other listed opcode it lasts 4 bytes if `ext_addr` was high when the opcode byte was accepted, and 3 bytes if it was low.
- R4: After the address bytes, `phase` is 2 (dummy) for a number of bytes set by the opcode: 1 for 0x0B, 0x3B, 0x6B, 0x3C, 0x6C; 2 for 0xBB, 0x0C, 0xBC; 5 for 0xEB, 0xEC; 0 (no dummy phase) for 0x03, 0x02, 0xA2, 0x32, 0x13, 0x12, 0x34.
- R5: Opcodes 0x3B, 0x3C, 0xA2 set `link_width` to 2, and 0x6B, 0x6C, 0x32, 0x34 set it to 4. The change happens on the edge that accepts the last of the (address length + dummy count) bytes that follow the opcode. `link_width` is always 1, 2 or 4.
- R6: Opcodes 0xBB and 0xBC set `link_width` to 2, and 0xEB and 0xEC set it to 4, on the edge that accepts the opcode byte.
- R7: While `phase` is 2, `dummy_clks` equals 8 divided by `link_width`. In every other phase it is 0.
- R8: After the last address or dummy byte, `phase` is 3 (data) and `stripe_mode` is 1. `phase` and `link_width` then stay put until chip select drops. `stripe_mode` is 0 in every other phase.
- R9: `in_ready` is always 1. A cycle with `in_valid` low and chip select active changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | High while the flash is selected; low returns to opcode phase |
| ext_addr | input | 1 | Selects 4-byte addressing for opcodes without a fixed address length |
| in_valid | input | 1 | Outgoing byte is present |
| in_ready | output | 1 | Always high; no back-pressure |
| in_byte | input | 8 | Outgoing byte |
| phase | output | 3 | 0 opcode, 1 address, 2 dummy, 3 data, 4 pass-through |
| link_width | output | 3 | Lines in use for the next byte: 1, 2 or 4 |
| dummy_clks | output | 4 | Clock cycles for the next dummy byte, 0 outside dummy phase |
| stripe_mode | output | 1 | High in the data phase |

## Verification
Every result is due one edge after the byte or the chip-select-low cycle that causes it, since one register stage lies between the inputs and every output. The bench drives inputs on the falling edge and updates its own model at the rising edge. It compares all four outputs a few nanoseconds later, well before the next falling edge. Late widening is checked on the exact edge that accepts the last address or dummy byte. Idle cycles inside a transaction are checked to leave the outputs unchanged.

// File: rtl/qsn_pkg.sv
package qsn_pkg;
  localparam int CNT_W  = 3;          // holds address length (<=4) and dummy count (<=5)
  localparam int PEND_W = CNT_W + 1;  // holds address length + dummy count

  typedef enum logic [2:0] {
    PH_OPCODE = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_PASS   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    WID_KEEP = 2'd0,
    WID_NOW  = 2'd1,
    WID_LATE = 2'd2
  } widen_e;

  typedef struct packed {
    logic             known;
    logic [CNT_W-1:0] addr_len;
    logic [CNT_W-1:0] dummies;
    widen_e           widen;
    logic [2:0]       target;
  } cmd_info_t;
endpackage

// File: rtl/qsn_opcode_decode.sv
module qsn_opcode_decode
  import qsn_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] opcode,
  input  logic              ext_addr,
  output cmd_info_t         info
);
  localparam logic [CNT_W-1:0] LEN3 = CNT_W'(3);
  localparam logic [CNT_W-1:0] LEN4 = CNT_W'(4);

  always_comb begin
    info.known    = 1'b1;
    info.addr_len = ext_addr ? LEN4 : LEN3;
    info.dummies  = '0;
    info.widen    = WID_KEEP;
    info.target   = 3'd1;
    case (opcode)
      8'h03, 8'h02: ;
      8'h13, 8'h12: info.addr_len = LEN4;
      8'h0B: info.dummies = CNT_W'(1);
      8'h0C: begin info.dummies = CNT_W'(2); info.addr_len = LEN4; end
      8'h3B: begin info.dummies = CNT_W'(1); info.widen = WID_LATE; info.target = 3'd2; end
      8'h3C: begin info.dummies = CNT_W'(1); info.widen = WID_LATE; info.target = 3'd2;
                   info.addr_len = LEN4; end
      8'h6B: begin info.dummies = CNT_W'(1); info.widen = WID_LATE; info.target = 3'd4; end
      8'h6C: begin info.dummies = CNT_W'(1); info.widen = WID_LATE; info.target = 3'd4;
                   info.addr_len = LEN4; end
      8'hA2: begin info.widen = WID_LATE; info.target = 3'd2; end
      8'h32: begin info.widen = WID_LATE; info.target = 3'd4; end
      8'h34: begin info.widen = WID_LATE; info.target = 3'd4; info.addr_len = LEN4; end
      8'hBB: begin info.dummies = CNT_W'(2); info.widen = WID_NOW; info.target = 3'd2; end
      8'hBC: begin info.dummies = CNT_W'(2); info.widen = WID_NOW; info.target = 3'd2;
                   info.addr_len = LEN4; end
      8'hEB: begin info.dummies = CNT_W'(5); info.widen = WID_NOW; info.target = 3'd4; end
      8'hEC: begin info.dummies = CNT_W'(5); info.widen = WID_NOW; info.target = 3'd4;
                   info.addr_len = LEN4; end
      default: info.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/qsn_phase_seq.sv
module qsn_phase_seq
  import qsn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      step,
  input  cmd_info_t info,
  output phase_e    phase
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] left;     // bytes remaining in current counted phase
  logic [CNT_W-1:0] dum_hold; // dummy count latched at the opcode

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_OPCODE;
      left     <= '0;
      dum_hold <= '0;
    end else if (clear) begin
      phase    <= PH_OPCODE;
      left     <= '0;
      dum_hold <= '0;
    end else if (step) begin
      case (phase)
        PH_OPCODE: begin
          if (info.known) begin
            phase    <= PH_ADDR;
            left     <= info.addr_len;
            dum_hold <= info.dummies;
          end else begin
            phase <= PH_PASS;
          end
        end
        PH_ADDR: begin
          if (left == ONE) begin
            if (dum_hold == '0) begin
              phase <= PH_DATA;
            end else begin
              phase <= PH_DUMMY;
              left  <= dum_hold;
            end
          end else begin
            left <= left - ONE;
          end
        end
        PH_DUMMY: begin
          if (left == ONE) phase <= PH_DATA;
          else             left  <= left - ONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/qsn_width_track.sv
module qsn_width_track
  import qsn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              load_now,
  input  logic              load_late,
  input  logic [2:0]        target,
  input  logic [PEND_W-1:0] late_cnt,
  output logic [2:0]        width
);
  localparam logic [PEND_W-1:0] ONE = PEND_W'(1);

  logic [PEND_W-1:0] pend;
  logic [2:0]        pend_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width  <= 3'd1;
      pend   <= '0;
      pend_w <= 3'd1;
    end else if (clear) begin
      width  <= 3'd1;
      pend   <= '0;
      pend_w <= 3'd1;
    end else if (step) begin
      if (pend != '0) begin
        pend <= pend - ONE;
        if (pend == ONE) width <= pend_w;
      end
      if (load_now) width <= target;
      if (load_late) begin
        pend   <= late_cnt;
        pend_w <= target;
      end
    end
  end
endmodule

// File: rtl/qspi_cmd_snoop.sv
module qspi_cmd_snoop
  import qsn_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_active,
  input  logic              ext_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [2:0]        phase,
  output logic [2:0]        link_width,
  output logic [3:0]        dummy_clks,
  output logic              stripe_mode
);
  cmd_info_t         info;
  phase_e            ph;
  logic              accept;
  logic              at_opcode;
  logic [PEND_W-1:0] late_cnt;
  logic [1:0]        wshift;

  assign in_ready  = 1'b1;
  assign accept    = in_valid & cs_active;
  assign at_opcode = (ph == PH_OPCODE);
  assign late_cnt  = {1'b0, info.addr_len} + {1'b0, info.dummies};

  qsn_opcode_decode #(.BYTE_W(BYTE_W)) u_dec (
    .opcode   (in_byte),
    .ext_addr (ext_addr),
    .info     (info)
  );

  qsn_phase_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (~cs_active),
    .step  (accept),
    .info  (info),
    .phase (ph)
  );

  qsn_width_track u_wid (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (~cs_active),
    .step      (accept),
    .load_now  (at_opcode & info.known & (info.widen == WID_NOW)),
    .load_late (at_opcode & info.known & (info.widen == WID_LATE)),
    .target    (info.target),
    .late_cnt  (late_cnt),
    .width     (link_width)
  );

  assign wshift      = {link_width[2], link_width[1]};
  assign phase       = ph;
  assign stripe_mode = (ph == PH_DATA);
  assign dummy_clks  = (ph == PH_DUMMY) ? (4'd8 >> wshift) : 4'd0;
endmodule

// File: rtl/qsn_snoop_checker.sv
module qsn_snoop_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_active,
  input logic       in_valid,
  input logic [2:0] phase,
  input logic [2:0] link_width,
  input logic [3:0] dummy_clks,
  input logic       stripe_mode
);
  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (phase == 3'd0 && link_width == 3'd1)); // R1
  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && phase == 3'd4) |=> (phase == 3'd4 && link_width == 3'd1)); // R2
  AST_OPC_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && in_valid && phase == 3'd0) |=> (phase == 3'd1 || phase == 3'd4)); // R3
  AST_WIDTH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(link_width) == 1); // R5
  AST_DUMMY_CLKS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd2) |-> ({3'b0, dummy_clks} * {4'b0, link_width} == 7'd8)); // R7
  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd2) |-> (dummy_clks == 4'd0)); // R7
  AST_DATA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && phase == 3'd3) |=> (phase == 3'd3 && $stable(link_width))); // R8
  AST_STRIPE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    stripe_mode |-> (phase == 3'd3)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !in_valid) |=> ($stable(phase) && $stable(link_width))); // R9
endmodule

bind qspi_cmd_snoop qsn_snoop_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_active   (cs_active),
  .in_valid    (in_valid),
  .phase       (phase),
  .link_width  (link_width),
  .dummy_clks  (dummy_clks),
  .stripe_mode (stripe_mode)
);

// File: tb/tb_qspi_cmd_snoop.sv
module tb_qspi_cmd_snoop;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_active = 1'b0;
  logic       ext_addr = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic [2:0] phase;
  logic [2:0] link_width;
  logic [3:0] dummy_clks;
  logic       stripe_mode;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  // bench model state
  int m_ph, m_w, m_pend, m_pw, m_left, m_dum;

  qspi_cmd_snoop dut (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .ext_addr(ext_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .phase(phase), .link_width(link_width), .dummy_clks(dummy_clks),
    .stripe_mode(stripe_mode)
  );

  always #5 clk = ~clk;

  function automatic int ref_dummies(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32, 8'h13, 8'h12, 8'h34: return 0;
      8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C:               return 1;
      8'hBB, 8'h0C, 8'hBC:                             return 2;
      8'hEB, 8'hEC:                                    return 5;
      default:                                         return -1;
    endcase
  endfunction

  function automatic int ref_alen(input logic [7:0] op, input logic ext);
    case (op)
      8'h13, 8'h12, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC, 8'h34: return 4;
      default: return ext ? 4 : 3;
    endcase
  endfunction

  // late target width (0 when none)
  function automatic int ref_late(input logic [7:0] op);
    case (op)
      8'h3B, 8'h3C, 8'hA2:        return 2;
      8'h6B, 8'h6C, 8'h32, 8'h34: return 4;
      default:                    return 0;
    endcase
  endfunction

  function automatic int ref_now(input logic [7:0] op);
    case (op)
      8'hBB, 8'hBC: return 2;
      8'hEB, 8'hEC: return 4;
      default:      return 0;
    endcase
  endfunction

  task automatic model_clear();
    m_ph = 0; m_w = 1; m_pend = 0; m_pw = 1; m_left = 0; m_dum = 0;
  endtask

  task automatic model_byte(input logic [7:0] b, input logic ext);
    if (m_pend != 0) begin
      m_pend--;
      if (m_pend == 0) m_w = m_pw;
    end
    case (m_ph)
      0: begin
        if (ref_dummies(b) < 0) m_ph = 4;
        else begin
          m_ph = 1; m_left = ref_alen(b, ext); m_dum = ref_dummies(b);
          if (ref_now(b) != 0) m_w = ref_now(b);
          if (ref_late(b) != 0) begin m_pend = m_left + m_dum; m_pw = ref_late(b); end
        end
      end
      1: begin
        m_left--;
        if (m_left == 0) begin
          if (m_dum == 0) m_ph = 3;
          else begin m_ph = 2; m_left = m_dum; end
        end
      end
      2: begin
        m_left--;
        if (m_left == 0) m_ph = 3;
      end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input bit idle);
    string pt;
    case (m_ph)
      0: pt = "R1 phase";
      1: pt = "R3 phase";
      2: pt = "R4 phase";
      3: pt = "R8 phase";
      default: pt = "R2 phase";
    endcase
    if (idle) pt = {pt, " (R9 idle)"};
    chk(pt, int'(phase), m_ph);
    chk("R5/R6 link_width", int'(link_width), m_w);
    chk("R7 dummy_clks", int'(dummy_clks), (m_ph == 2) ? 8 / m_w : 0);
    chk("R8 stripe_mode", int'(stripe_mode), (m_ph == 3) ? 1 : 0);
    chk("R9 in_ready", int'(in_ready), 1);
  endtask

  // one clock: drive at negedge, model at posedge, compare shortly after
  task automatic step(input logic cs, input logic v, input logic [7:0] b, input logic ext);
    @(negedge clk);
    cs_active = cs; in_valid = v; in_byte = b; ext_addr = ext;
    @(posedge clk);
    if (!cs) model_clear();
    else if (v) model_byte(b, ext);
    #2;
    compare_all(cs && !v);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000 && !done) begin
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual %0d expected <190000 cycles", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [17] = '{8'h03, 8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB, 8'h02, 8'hA2,
                             8'h32, 8'h13, 8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC, 8'h12, 8'h34};
    int seed_v;
    seed_v = $urandom(32'd20240611);
    model_clear();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset width", int'(link_width), 1);
    chk("R1 reset dummy_clks", int'(dummy_clks), 0);
    chk("R1 reset stripe", int'(stripe_mode), 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b0);

    // R6: quad I/O read widens on the opcode edge, 5 dummies at 2 clocks
    step(1'b1, 1'b1, 8'hEB, 1'b0);
    chk("R6 QIO width after opcode", int'(link_width), 4);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 8'h55, 1'b0);
    chk("R4 QIO dummy phase", int'(phase), 2);
    chk("R7 QIO dummy clocks", int'(dummy_clks), 2);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 8'h00, 1'b0);
    chk("R8 QIO data", int'(stripe_mode), 1);
    step(1'b0, 1'b0, 8'h00, 1'b0);

    // R5: dual output read widens only after addr + dummy bytes
    step(1'b1, 1'b1, 8'h3B, 1'b1);
    chk("R5 DOR width held", int'(link_width), 1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'hA5, 1'b0);
    chk("R3 ext addr gives 4 bytes", int'(phase), 2);
    chk("R7 DOR dummy clocks", int'(dummy_clks), 8);
    step(1'b1, 1'b1, 8'h00, 1'b0);
    chk("R5 DOR width after dummy", int'(link_width), 2);
    step(1'b0, 1'b0, 8'h00, 1'b0);

    // R1: drop chip select with a pending change, then a plain read
    step(1'b1, 1'b1, 8'h32, 1'b0);
    step(1'b1, 1'b1, 8'h01, 1'b0);
    step(1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b1, 8'h03, 1'b0);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8'h11, 1'b0);
    chk("R1 pending change dropped", int'(link_width), 1);
    step(1'b0, 1'b0, 8'h00, 1'b0);

    // R2: unknown opcode
    step(1'b1, 1'b1, 8'h9F, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 8'hEB, 1'b0);
    chk("R2 pass-through sticky", int'(phase), 4);
    step(1'b0, 1'b0, 8'h00, 1'b0);

    // random transactions
    for (int t = 0; t < 600; t++) begin
      logic [7:0] op;
      logic ext;
      int nb;
      ext = 1'($urandom_range(0, 1));
      op = ($urandom_range(0, 9) == 0) ? 8'($urandom) : ops[$urandom_range(0, 16)];
      step(1'b1, 1'b1, op, ext);
      nb = $urandom_range(0, 14);
      for (int k = 0; k < nb; k++) begin
        if ($urandom_range(0, 3) == 0) step(1'b1, 1'b0, 8'($urandom), 1'($urandom_range(0, 1)));
        step(1'b1, 1'b1, 8'($urandom), 1'($urandom_range(0, 1)));
      end
      step(1'b0, 1'b0, 8'($urandom), 1'b0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule